// File: doc/BRIEF.md
# Per-Thread Squash and Trap Controller

This block sits in the retirement stage of a multithreaded out-of-order core and decides, for each hardware thread, when the in-flight work of that thread is thrown away. Three things can request this. A faulting instruction at retirement starts a trap. An external request can replace the thread's architectural context. The execute stage can report a branch misprediction or a replay. The block tracks each thread's retirement status and the youngest sequence number accepted for that thread. When a squash is taken, it sends the reorder buffer a one-cycle squash command with a boundary sequence number, plus the restart PC pair and branch information for the front of the pipe.

A trap does not squash at once. It holds a trap-in-flight bit for a programmable number of cycles, and only then raises its internal squash flag. A trap squash and a context squash both discard the whole thread. Their boundary comes from the buffer's head entry, and the restart PC pair is the one saved from retirement. An execute squash is taken only when it names an instruction no younger than the youngest one recorded, so an older squash is never overridden by a younger one. After any squash the thread stays in a squashing state until the buffer reports that the squash is complete. Instructions that arrive for the thread while it is squashing or waiting on a trap are dropped.

Top module: `sqctl_top`

## Requirements
- R1: After reset every thread has status Idle, youngest sequence 0, and trap_inflight, sq_cmd, rob_squashing and ins_accept all low.
- R2: Status codes are Idle=0, Running=1, ROBSquashing=2, TrapPending=3 and FetchTrapPending=4. An accepted insert records its sequence number as the thread's youngest one, and an accepted insert moves an Idle thread to Running.
- R3: A trap_req on a Running thread moves it to TrapPending and sets trap_inflight on the next cycle. The squash command appears L+1 cycles after trap_inflight rises, where L is trap_lat (a value of 0 acts as 1). trap_inflight falls in the same cycle that the squash command appears.
- R4: A trap or context squash discards the whole thread, with the following outputs:
  - sq_seq is rob_head_seq-1, or 0 when rob_empty is high.
  - youngest becomes 0.
  - rs_pc and rs_npc are the pair last loaded through pcu_valid.
  - rs_taken and rs_mispred are 0.
- R5: A tc_req produces a squash command two cycles after the cycle in which it is presented. A tc_req is ignored while trap_inflight is high or the thread is TrapPending.
- R6: An execute squash is taken only when both of these hold: the thread is not TrapPending, and ex_seq is less than or equal to the youngest sequence (unsigned). Otherwise it has no effect on sq_cmd, status or youngest.
- R7: A taken execute squash produces the following outputs on the next cycle:
  - sq_cmd is 1.
  - sq_seq is ex_seq, or ex_seq-1 when ex_incl is high; youngest takes the same value.
  - rs_pc is ex_npc and rs_npc is ex_npc+INSN_BYTES.
  - ex_mis_pc, ex_taken and ex_mispred are forwarded.
- R8: After a squash the thread reads ROBSquashing, and rob_squashing is high in every cycle until rob_sq_done is sampled. On the cycle after that sampling, the status is Running.
- R9: An insert is not accepted (ins_accept low, youngest unchanged) in any of these cases: the thread is ROBSquashing, the thread is TrapPending, or a squash is taken in that cycle.
- R10: When a trap or context squash is taken in the same cycle as a valid execute squash, the whole-thread squash wins and the execute fields are not forwarded.
- R11: Threads are independent: activity on one thread changes no output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_lat | input | LAT_W | Trap delay in cycles, 0 acts as 1 |
| trap_req | input | NT | Faulting instruction retires, start a trap |
| tc_req | input | NT | External context squash request |
| pcu_valid | input | NT | Load the saved restart PC pair |
| pcu_pc | input | NT*PC_W | Restart PC to save |
| pcu_npc | input | NT*PC_W | Restart next-PC to save |
| ins_valid | input | NT | Instruction arriving for insertion |
| ins_seq | input | NT*SEQ_W | Sequence number of arriving instruction |
| ex_valid | input | NT | Execute-stage squash request |
| ex_seq | input | NT*SEQ_W | Sequence number being squashed |
| ex_incl | input | NT | Squash includes the named instruction |
| ex_npc | input | NT*PC_W | Redirect PC from execute |
| ex_mis_pc | input | NT*PC_W | PC of the mispredicted instruction |
| ex_taken | input | NT | Branch taken flag |
| ex_mispred | input | NT | Branch mispredict flag |
| rob_empty | input | NT | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NT*SEQ_W | Sequence number at the buffer head |
| rob_sq_done | input | NT | Buffer finished the thread's squash |
| status | output | NT*3 | Per-thread status code |
| trap_inflight | output | NT | Trap delay running |
| ins_accept | output | NT | Arriving instruction accepted (combinational) |
| sq_cmd | output | NT | One-cycle squash command |
| rob_squashing | output | NT | Thread is squashing |
| sq_seq | output | NT*SEQ_W | Squash boundary and done sequence |
| youngest | output | NT*SEQ_W | Youngest recorded sequence number |
| rs_pc | output | NT*PC_W | Restart PC |
| rs_npc | output | NT*PC_W | Restart next-PC |
| rs_mis_pc | output | NT*PC_W | Forwarded mispredict PC |
| rs_taken | output | NT | Forwarded branch taken |
| rs_mispred | output | NT | Forwarded mispredict flag |

## Verification
A wrong youngest register shows at the ports within one cycle. It makes ins_accept or the acceptance of the next execute squash disagree, and it also shows directly on youngest. A miscounting trap timer moves the squash command off its cycle, L+1 cycles after trap_inflight rises, so counting cycles from that edge exposes it. A status register stuck in ROBSquashing or TrapPending shows as a dropped insert on the very next attempt. A lost priority shows as execute fields on rs_pc in the cycle of a whole-thread squash.

// File: rtl/sqctl_pkg.sv
package sqctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_ROBSQ = 3'd2,
    ST_TRAP  = 3'd3,
    ST_FTRAP = 3'd4
  } thr_st_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TRAP = 2'd1,
    SRC_TC   = 2'd2,
    SRC_EX   = 2'd3
  } sq_src_e;
endpackage

// File: rtl/sqctl_bound.sv
module sqctl_bound #(
  parameter int unsigned SEQ_W = 16
) (
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] head_seq,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic [SEQ_W-1:0] young,
  output logic [SEQ_W-1:0] full_b,
  output logic [SEQ_W-1:0] ex_b,
  output logic             ex_older
);
  function automatic logic [SEQ_W-1:0] full_boundary(input logic empty,
                                                      input logic [SEQ_W-1:0] head);
    return empty ? '0 : head - SEQ_W'(1);
  endfunction

  function automatic logic [SEQ_W-1:0] ex_boundary(input logic [SEQ_W-1:0] s,
                                                    input logic incl);
    return incl ? s - SEQ_W'(1) : s;
  endfunction

  function automatic logic not_younger(input logic [SEQ_W-1:0] s,
                                       input logic [SEQ_W-1:0] y);
    return s <= y;
  endfunction

  assign full_b   = full_boundary(rob_empty, head_seq);
  assign ex_b     = ex_boundary(ex_seq, ex_incl);
  assign ex_older = not_younger(ex_seq, young);
endmodule

// File: rtl/sqctl_trap_timer.sv
module sqctl_trap_timer #(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [LAT_W-1:0] lat,
  output logic             inflight,
  output logic             fire
);
  logic [LAT_W-1:0] cnt_q;
  logic             inflight_q;
  logic             fire_q;
  logic             last_tick;

  function automatic logic [LAT_W-1:0] eff_lat(input logic [LAT_W-1:0] l);
    return (l == '0) ? LAT_W'(1) : l;
  endfunction

  assign last_tick = (cnt_q == eff_lat(lat) - LAT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      inflight_q <= 1'b0;
      fire_q     <= 1'b0;
    end else if (take) begin
      cnt_q      <= '0;
      inflight_q <= 1'b0;
      fire_q     <= 1'b0;
    end else if (start) begin
      cnt_q      <= '0;
      inflight_q <= 1'b1;
      fire_q     <= 1'b0;
    end else if (inflight_q && !fire_q) begin
      if (last_tick) fire_q <= 1'b1;
      else           cnt_q  <= cnt_q + LAT_W'(1);
    end
  end

  assign inflight = inflight_q;
  assign fire     = fire_q;

  // R3
  timer_fire_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> inflight_q);

  // R3
  timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !take) |=> (inflight_q && !fire_q));
endmodule

// File: rtl/sqctl_thread.sv
module sqctl_thread
  import sqctl_pkg::*;
#(
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned LAT_W      = 4,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAT_W-1:0] trap_lat,
  input  logic             trap_req,
  input  logic             tc_req,
  input  logic             pcu_valid,
  input  logic [PC_W-1:0]  pcu_pc,
  input  logic [PC_W-1:0]  pcu_npc,
  input  logic             ins_valid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             ex_valid,
  input  logic [SEQ_W-1:0] ex_seq,
  input  logic             ex_incl,
  input  logic [PC_W-1:0]  ex_npc,
  input  logic [PC_W-1:0]  ex_mis_pc,
  input  logic             ex_taken,
  input  logic             ex_mispred,
  input  logic             rob_empty,
  input  logic [SEQ_W-1:0] rob_head_seq,
  input  logic             rob_sq_done,
  output logic [2:0]       status,
  output logic             trap_inflight,
  output logic             ins_accept,
  output logic             sq_cmd,
  output logic             rob_squashing,
  output logic [SEQ_W-1:0] sq_seq,
  output logic [SEQ_W-1:0] youngest,
  output logic [PC_W-1:0]  rs_pc,
  output logic [PC_W-1:0]  rs_npc,
  output logic [PC_W-1:0]  rs_mis_pc,
  output logic             rs_taken,
  output logic             rs_mispred
);
  thr_st_e          st_q;
  logic [SEQ_W-1:0] young_q;
  logic             tcp_q;
  logic [PC_W-1:0]  spc_q, snpc_q;
  logic             sq_q;
  logic [SEQ_W-1:0] sq_seq_q;
  logic [PC_W-1:0]  rs_pc_q, rs_npc_q, rs_mpc_q;
  logic             rs_tk_q, rs_mp_q;

  logic             tinf, tsq;
  logic [SEQ_W-1:0] full_b, ex_b;
  logic             ex_older;

  // named internal events
  logic    take_trap, take_tc, take_full, take_ex, sq_now;
  logic    tc_ok, trap_ok, ins_ok, blocked;
  sq_src_e src;

  function automatic logic [PC_W-1:0] next_fetch(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INSN_BYTES);
  endfunction

  sqctl_bound #(.SEQ_W(SEQ_W)) u_bound (
    .rob_empty(rob_empty), .head_seq(rob_head_seq), .ex_seq(ex_seq),
    .ex_incl(ex_incl), .young(young_q), .full_b(full_b), .ex_b(ex_b),
    .ex_older(ex_older)
  );

  sqctl_trap_timer #(.LAT_W(LAT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(trap_ok), .take(take_trap),
    .lat(trap_lat), .inflight(tinf), .fire(tsq)
  );

  always_comb begin
    take_trap = tsq;
    take_tc   = tcp_q && !tsq;
    take_full = take_trap || take_tc;
    take_ex   = ex_valid && (st_q != ST_TRAP) && ex_older && !take_full;
    sq_now    = take_full || take_ex;
    blocked   = (st_q == ST_ROBSQ) || (st_q == ST_TRAP);
    tc_ok     = tc_req && !tinf && (st_q != ST_TRAP) && !take_tc;
    trap_ok   = trap_req && (st_q == ST_RUN) && !sq_now && !tcp_q;
    ins_ok    = ins_valid && !blocked && !sq_now && !trap_ok;
    if (take_trap)    src = SRC_TRAP;
    else if (take_tc) src = SRC_TC;
    else if (take_ex) src = SRC_EX;
    else              src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      young_q <= '0;
      tcp_q   <= 1'b0;
      spc_q   <= '0;
      snpc_q  <= '0;
    end else begin
      if (sq_now)                                st_q <= ST_ROBSQ;
      else if (trap_ok)                          st_q <= ST_TRAP;
      else if (st_q == ST_ROBSQ && rob_sq_done)  st_q <= ST_RUN;
      else if (ins_ok && st_q == ST_IDLE)        st_q <= ST_RUN;

      if (take_full)    young_q <= '0;
      else if (take_ex) young_q <= ex_b;
      else if (ins_ok)  young_q <= ins_seq;

      if (take_tc)    tcp_q <= 1'b0;
      else if (tc_ok) tcp_q <= 1'b1;

      if (pcu_valid) begin
        spc_q  <= pcu_pc;
        snpc_q <= pcu_npc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q     <= 1'b0;
      sq_seq_q <= '0;
      rs_pc_q  <= '0;
      rs_npc_q <= '0;
      rs_mpc_q <= '0;
      rs_tk_q  <= 1'b0;
      rs_mp_q  <= 1'b0;
    end else begin
      sq_q <= sq_now;
      unique case (src)
        SRC_TRAP, SRC_TC: begin
          sq_seq_q <= full_b;
          rs_pc_q  <= spc_q;
          rs_npc_q <= snpc_q;
          rs_mpc_q <= '0;
          rs_tk_q  <= 1'b0;
          rs_mp_q  <= 1'b0;
        end
        SRC_EX: begin
          sq_seq_q <= ex_b;
          rs_pc_q  <= ex_npc;
          rs_npc_q <= next_fetch(ex_npc);
          rs_mpc_q <= ex_mis_pc;
          rs_tk_q  <= ex_taken;
          rs_mp_q  <= ex_mispred;
        end
        default: ;
      endcase
    end
  end

  assign status        = st_q;
  assign trap_inflight = tinf;
  assign ins_accept    = ins_ok;
  assign sq_cmd        = sq_q;
  assign rob_squashing = (st_q == ST_ROBSQ);
  assign sq_seq        = sq_seq_q;
  assign youngest      = young_q;
  assign rs_pc         = rs_pc_q;
  assign rs_npc        = rs_npc_q;
  assign rs_mis_pc     = rs_mpc_q;
  assign rs_taken      = rs_tk_q;
  assign rs_mispred    = rs_mp_q;

  // R5
  trap_tc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tsq && tcp_q));

  // R8
  robsq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_ROBSQ && st_q == ST_RUN) |-> $past(rob_sq_done));

  // R9
  drop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_accept |-> !((st_q == ST_ROBSQ) || (st_q == ST_TRAP)));

  // R6
  trap_wait_no_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAP && !tsq) |=> !sq_q);

  // R8
  squash_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_q |-> rob_squashing);

  // R4
  full_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_full |=> (young_q == '0 && !rs_mp_q));
endmodule

// File: rtl/sqctl_top.sv
module sqctl_top #(
  parameter int unsigned NT         = 2,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned LAT_W      = 4,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    trap_lat,
  input  logic [NT-1:0]       trap_req,
  input  logic [NT-1:0]       tc_req,
  input  logic [NT-1:0]       pcu_valid,
  input  logic [NT*PC_W-1:0]  pcu_pc,
  input  logic [NT*PC_W-1:0]  pcu_npc,
  input  logic [NT-1:0]       ins_valid,
  input  logic [NT*SEQ_W-1:0] ins_seq,
  input  logic [NT-1:0]       ex_valid,
  input  logic [NT*SEQ_W-1:0] ex_seq,
  input  logic [NT-1:0]       ex_incl,
  input  logic [NT*PC_W-1:0]  ex_npc,
  input  logic [NT*PC_W-1:0]  ex_mis_pc,
  input  logic [NT-1:0]       ex_taken,
  input  logic [NT-1:0]       ex_mispred,
  input  logic [NT-1:0]       rob_empty,
  input  logic [NT*SEQ_W-1:0] rob_head_seq,
  input  logic [NT-1:0]       rob_sq_done,
  output logic [NT*3-1:0]     status,
  output logic [NT-1:0]       trap_inflight,
  output logic [NT-1:0]       ins_accept,
  output logic [NT-1:0]       sq_cmd,
  output logic [NT-1:0]       rob_squashing,
  output logic [NT*SEQ_W-1:0] sq_seq,
  output logic [NT*SEQ_W-1:0] youngest,
  output logic [NT*PC_W-1:0]  rs_pc,
  output logic [NT*PC_W-1:0]  rs_npc,
  output logic [NT*PC_W-1:0]  rs_mis_pc,
  output logic [NT-1:0]       rs_taken,
  output logic [NT-1:0]       rs_mispred
);
  for (genvar t = 0; t < NT; t++) begin : g_thr
    sqctl_thread #(
      .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W), .INSN_BYTES(INSN_BYTES)
    ) u_thr (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_lat     (trap_lat),
      .trap_req     (trap_req[t]),
      .tc_req       (tc_req[t]),
      .pcu_valid    (pcu_valid[t]),
      .pcu_pc       (pcu_pc[t*PC_W +: PC_W]),
      .pcu_npc      (pcu_npc[t*PC_W +: PC_W]),
      .ins_valid    (ins_valid[t]),
      .ins_seq      (ins_seq[t*SEQ_W +: SEQ_W]),
      .ex_valid     (ex_valid[t]),
      .ex_seq       (ex_seq[t*SEQ_W +: SEQ_W]),
      .ex_incl      (ex_incl[t]),
      .ex_npc       (ex_npc[t*PC_W +: PC_W]),
      .ex_mis_pc    (ex_mis_pc[t*PC_W +: PC_W]),
      .ex_taken     (ex_taken[t]),
      .ex_mispred   (ex_mispred[t]),
      .rob_empty    (rob_empty[t]),
      .rob_head_seq (rob_head_seq[t*SEQ_W +: SEQ_W]),
      .rob_sq_done  (rob_sq_done[t]),
      .status       (status[t*3 +: 3]),
      .trap_inflight(trap_inflight[t]),
      .ins_accept   (ins_accept[t]),
      .sq_cmd       (sq_cmd[t]),
      .rob_squashing(rob_squashing[t]),
      .sq_seq       (sq_seq[t*SEQ_W +: SEQ_W]),
      .youngest     (youngest[t*SEQ_W +: SEQ_W]),
      .rs_pc        (rs_pc[t*PC_W +: PC_W]),
      .rs_npc       (rs_npc[t*PC_W +: PC_W]),
      .rs_mis_pc    (rs_mis_pc[t*PC_W +: PC_W]),
      .rs_taken     (rs_taken[t]),
      .rs_mispred   (rs_mispred[t])
    );
  end
endmodule

// File: tb/test_sqctl_top.sv
module test_sqctl_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, SW = 16, PW = 32, LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [LW-1:0]    trap_lat;
  logic [NT-1:0]    trap_req, tc_req, pcu_valid, ins_valid, ex_valid, ex_incl;
  logic [NT-1:0]    ex_taken, ex_mispred, rob_empty, rob_sq_done;
  logic [NT*PW-1:0] pcu_pc, pcu_npc, ex_npc, ex_mis_pc;
  logic [NT*SW-1:0] ins_seq, ex_seq, rob_head_seq;
  logic [NT*3-1:0]  status;
  logic [NT-1:0]    trap_inflight, ins_accept, sq_cmd, rob_squashing, rs_taken, rs_mispred;
  logic [NT*SW-1:0] sq_seq, youngest;
  logic [NT*PW-1:0] rs_pc, rs_npc, rs_mis_pc;

  sqctl_top #(.NT(NT), .SEQ_W(SW), .PC_W(PW), .LAT_W(LW)) i_sqctl_top (
    .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .trap_req(trap_req),
    .tc_req(tc_req), .pcu_valid(pcu_valid), .pcu_pc(pcu_pc), .pcu_npc(pcu_npc),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ex_valid(ex_valid), .ex_seq(ex_seq),
    .ex_incl(ex_incl), .ex_npc(ex_npc), .ex_mis_pc(ex_mis_pc), .ex_taken(ex_taken),
    .ex_mispred(ex_mispred), .rob_empty(rob_empty), .rob_head_seq(rob_head_seq),
    .rob_sq_done(rob_sq_done), .status(status), .trap_inflight(trap_inflight),
    .ins_accept(ins_accept), .sq_cmd(sq_cmd), .rob_squashing(rob_squashing),
    .sq_seq(sq_seq), .youngest(youngest), .rs_pc(rs_pc), .rs_npc(rs_npc),
    .rs_mis_pc(rs_mis_pc), .rs_taken(rs_taken), .rs_mispred(rs_mispred)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected boundaries, written from the requirement text
  function automatic logic [SW-1:0] want_ex(input logic [SW-1:0] s, input logic incl);
    logic [SW-1:0] d;
    d = {{(SW-1){1'b0}}, incl};
    return s - d;
  endfunction

  function automatic logic [SW-1:0] want_full(input logic empty, input logic [SW-1:0] h);
    if (empty) return '0;
    return h + {SW{1'b1}};
  endfunction

  function automatic logic [2:0] st_of(input int t);
    return status[t*3 +: 3];
  endfunction

  function automatic logic [SW-1:0] yg_of(input int t);
    return youngest[t*SW +: SW];
  endfunction

  function automatic logic [SW-1:0] sqs_of(input int t);
    return sq_seq[t*SW +: SW];
  endfunction

  task automatic clr();
    trap_req = '0; tc_req = '0; pcu_valid = '0; ins_valid = '0;
    ex_valid = '0; ex_incl = '0; ex_taken = '0; ex_mispred = '0;
    rob_sq_done = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    clr();
  endtask

  task automatic do_ins(input int t, input logic [SW-1:0] s);
    ins_valid[t] = 1'b1;
    ins_seq[t*SW +: SW] = s;
  endtask

  task automatic do_ex(input int t, input logic [SW-1:0] s, input logic incl,
                       input logic [PW-1:0] npc, input logic [PW-1:0] mpc,
                       input logic tk, input logic mp);
    ex_valid[t] = 1'b1;
    ex_seq[t*SW +: SW] = s;
    ex_incl[t] = incl;
    ex_npc[t*PW +: PW] = npc;
    ex_mis_pc[t*PW +: PW] = mpc;
    ex_taken[t] = tk;
    ex_mispred[t] = mp;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int          m_st;
    logic [SW-1:0] m_young;
    void'($urandom(32'd1234));
    trap_lat = 4'd3;
    pcu_pc = '0; pcu_npc = '0; ins_seq = '0; ex_seq = '0; ex_npc = '0; ex_mis_pc = '0;
    rob_empty = '0;
    rob_head_seq = {NT{16'd30}};
    clr();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 status", 64'(status), 64'd0);
    chk("R1 youngest", 64'(youngest), 64'd0);
    chk("R1 flags", 64'({trap_inflight, sq_cmd, rob_squashing, ins_accept}), 64'd0);
    rst_n = 1'b1;
    cyc();

    // R2 insert moves Idle to Running
    do_ins(0, 16'd10);
    #1 chk("R2 accept", 64'(ins_accept[0]), 64'd1);
    cyc();
    chk("R2 status run", 64'(st_of(0)), 64'd1);
    chk("R2 youngest", 64'(yg_of(0)), 64'd10);
    do_ins(0, 16'd20);
    pcu_valid[0] = 1'b1; pcu_pc[0 +: PW] = 32'h1000; pcu_npc[0 +: PW] = 32'h1004;
    cyc();
    chk("R2 youngest2", 64'(yg_of(0)), 64'd20);

    // R6 younger execute squash ignored
    do_ex(0, 16'd25, 1'b0, 32'h9000, 32'h8ff0, 1'b1, 1'b1);
    cyc();
    chk("R6 ignored sq", 64'(sq_cmd[0]), 64'd0);
    chk("R6 ignored st", 64'(st_of(0)), 64'd1);
    chk("R6 ignored young", 64'(yg_of(0)), 64'd20);

    // R7 accepted execute squash
    do_ex(0, 16'd15, 1'b0, 32'h2000, 32'h1ff0, 1'b1, 1'b1);
    cyc();
    chk("R7 sq", 64'(sq_cmd[0]), 64'd1);
    chk("R7 seq", 64'(sqs_of(0)), 64'(want_ex(16'd15, 1'b0)));
    chk("R7 young", 64'(yg_of(0)), 64'd15);
    chk("R7 pc", 64'(rs_pc[0 +: PW]), 64'h2000);
    chk("R7 npc", 64'(rs_npc[0 +: PW]), 64'h2004);
    chk("R7 mpc", 64'(rs_mis_pc[0 +: PW]), 64'h1ff0);
    chk("R7 flags", 64'({rs_taken[0], rs_mispred[0]}), 64'd3);
    chk("R8 robsq", 64'({st_of(0), rob_squashing[0]}), 64'({3'd2, 1'b1}));
    chk("R11 other thread", 64'({sq_cmd[1], st_of(1)}), 64'd0);

    // R9 drop while squashing, R8 hold
    do_ins(0, 16'd40);
    #1 chk("R9 drop", 64'(ins_accept[0]), 64'd0);
    cyc();
    chk("R8 pulse one cycle", 64'(sq_cmd[0]), 64'd0);
    chk("R8 still squashing", 64'(rob_squashing[0]), 64'd1);
    chk("R9 young kept", 64'(yg_of(0)), 64'd15);
    rob_sq_done[0] = 1'b1;
    cyc();
    chk("R8 back to run", 64'({st_of(0), rob_squashing[0]}), 64'({3'd1, 1'b0}));

    // R7 include flag
    do_ex(0, 16'd12, 1'b1, 32'h2100, 32'h20f0, 1'b0, 1'b0);
    cyc();
    chk("R7 incl seq", 64'(sqs_of(0)), 64'(want_ex(16'd12, 1'b1)));
    chk("R7 incl young", 64'(yg_of(0)), 64'd11);
    rob_sq_done[0] = 1'b1;
    cyc();

    // R3 trap with latency 3
    trap_req[0] = 1'b1;
    cyc();
    chk("R3 trap status", 64'(st_of(0)), 64'd3);
    chk("R3 inflight", 64'(trap_inflight[0]), 64'd1);
    tc_req[0] = 1'b1;
    do_ins(0, 16'd50);
    #1 chk("R9 drop in trap", 64'(ins_accept[0]), 64'd0);
    cyc();
    chk("R3 wait1", 64'(sq_cmd[0]), 64'd0);
    do_ex(0, 16'd0, 1'b0, 32'h7000, 32'h7000, 1'b1, 1'b1);
    cyc();
    chk("R5 tc ignored", 64'(sq_cmd[0]), 64'd0);
    cyc();
    chk("R6 ex ignored in trap", 64'(sq_cmd[0]), 64'd0);
    chk("R3 still inflight", 64'(trap_inflight[0]), 64'd1);
    cyc();
    chk("R3 squash at L+1", 64'(sq_cmd[0]), 64'd1);
    chk("R3 inflight falls", 64'(trap_inflight[0]), 64'd0);
    chk("R4 seq head-1", 64'(sqs_of(0)), 64'(want_full(1'b0, 16'd30)));
    chk("R4 pc", 64'({rs_pc[0 +: PW], rs_npc[0 +: PW]}), {32'h1000, 32'h1004});
    chk("R4 flags", 64'({rs_taken[0], rs_mispred[0]}), 64'd0);
    chk("R4 young", 64'(yg_of(0)), 64'd0);
    rob_sq_done[0] = 1'b1;
    cyc();
    chk("R8 run after trap", 64'(st_of(0)), 64'd1);

    // R5 context squash, R10 priority over execute
    pcu_valid[0] = 1'b1; pcu_pc[0 +: PW] = 32'h3000; pcu_npc[0 +: PW] = 32'h3004;
    cyc();
    rob_empty[0] = 1'b1;
    tc_req[0] = 1'b1;
    cyc();
    chk("R5 not yet", 64'(sq_cmd[0]), 64'd0);
    do_ex(0, 16'd0, 1'b0, 32'hdead, 32'hbeef, 1'b1, 1'b1);
    cyc();
    chk("R5 tc squash", 64'(sq_cmd[0]), 64'd1);
    chk("R4 empty seq", 64'(sqs_of(0)), 64'(want_full(1'b1, 16'd30)));
    chk("R10 full wins pc", 64'(rs_pc[0 +: PW]), 64'h3000);
    chk("R10 full wins flags", 64'({rs_taken[0], rs_mispred[0]}), 64'd0);
    rob_empty[0] = 1'b0;
    rob_sq_done[0] = 1'b1;
    cyc();

    // R3 latency 0 acts as 1
    trap_lat = 4'd0;
    trap_req[0] = 1'b1;
    cyc();
    chk("R3 lat0 inflight", 64'(trap_inflight[0]), 64'd1);
    cyc();
    chk("R3 lat0 wait", 64'(sq_cmd[0]), 64'd0);
    cyc();
    chk("R3 lat0 squash", 64'(sq_cmd[0]), 64'd1);
    rob_sq_done[0] = 1'b1;
    cyc();
    trap_lat = 4'd3;

    // R11 thread 1 untouched so far
    chk("R11 thread1 idle", 64'({st_of(1), yg_of(1)}), 64'd0);

    // random phase on thread 1
    m_st = 0;
    m_young = '0;
    for (int i = 0; i < 400; i++) begin
      logic ev, ei, iv, dn, ex_ok, acc;
      logic [SW-1:0] es, is_;
      ev  = ($urandom % 5) == 0;
      ei  = $urandom % 2;
      es  = m_young + SW'($urandom % 8) - SW'(4);
      iv  = $urandom % 2;
      is_ = m_young + SW'(1 + $urandom % 3);
      dn  = ($urandom % 3) == 0;
      if (ev) do_ex(1, es, ei, 32'h4000 + 32'(i), 32'h5000 + 32'(i), 1'b0, 1'b1);
      if (iv) do_ins(1, is_);
      rob_sq_done[1] = dn;
      ex_ok = ev && (m_st != 3) && (es <= m_young);
      acc   = iv && (m_st == 0 || m_st == 1) && !ex_ok;
      #1 chk("R9 rnd accept", 64'(ins_accept[1]), 64'(acc));
      cyc();
      if (ex_ok) begin
        m_st = 2;
        m_young = want_ex(es, ei);
      end else if (m_st == 2 && dn) begin
        m_st = 1;
      end
      if (acc) begin
        m_young = is_;
        if (m_st == 0) m_st = 1;
      end
      chk("R6 rnd sq", 64'(sq_cmd[1]), 64'(ex_ok));
      if (ex_ok) chk("R7 rnd seq", 64'(sqs_of(1)), 64'(m_young));
      chk("R8 rnd status", 64'(st_of(1)), 64'(m_st));
      chk("R2 rnd young", 64'(yg_of(1)), 64'(m_young));
      chk("R11 rnd thread0", 64'(sq_cmd[0]), 64'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule